// File: doc/BRIEF.md
# PCI Power Management Capability Registers

This block holds the register state of a PCI power management capability. It has two parts. The first is a fixed capabilities word, which reports the interface version and which optional low-power states the function supports. The second is a 16-bit control/status word. Through it, configuration software reads and sets the device power state, chooses a data-select index, and enables or acknowledges power-management events (PME). The bus protocol, the data register contents and any real clock or power gating are handled elsewhere.

Device logic reports wake-worthy conditions on `pme_event`. The block records each one in a sticky status bit, whether or not PME is enabled. It drives `pme_out` from a register, so the line is high only while the status bit and the enable bit are both set. Software acknowledges an event by writing 1 to the status bit. A power-state write that names a state the function does not support completes normally, but it has no effect. The supported set always contains D0 and D3. The parameter `SUPPORTED_MASK` decides whether D1 and D2 are in the set.

Top module: `pm_cap_regs`

## Requirements
- R1: A synchronous reset clears the power state to D0 (code 00), the data select to 0, the PME status to 0 and `pme_out` to 0.
- R2: PME enable (control word bit 8) takes the value of `aux_present` during reset. After reset it follows writes to bit 8 when byte lane 1 is enabled.
- R3: Power-state codes are 00=D0, 01=D1, 10=D2 and 11=D3. A write to control bits 1:0 with a supported code loads that state, and `pwr_state` shows it from the next cycle.
- R4: A write of an unsupported code (D1 or D2 whose mask bit is 0) leaves the power state unchanged.
- R5: PME status (control bit 15) sets in the cycle after `pme_event` is high, whatever the enable bit holds.
- R6: Writing 1 to bit 15 clears PME status. Writing 0 leaves it as it is. An event in the same cycle as a clearing write keeps the status set.
- R7: `pme_out` is registered and equals status AND enable as they stand after each clock edge. It is low in the cycle after a clearing write.
- R8: Byte lane 0 (`cfg_be[0]`) covers control bits 7:0, and byte lane 1 covers bits 15:8. Fields in a disabled lane keep their values.
- R9: Control bits 12:9 are a read/write data select. Bits 14:13 read 01. Bits 7:2 read 0.
- R10: The capabilities word at index 0 reads version 010 in bits 2:0 and zeros in bits 8:3. Bit 9 reports D1 support and bit 10 reports D2 support; all higher bits are 0. Writes to it are ignored.
- R11: Index 2 (bridge extension and data byte) and index 3 read as zero, and writes to them have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_addr | input | ADDR_W | 16-bit word index inside the capability |
| cfg_be | input | 2 | Byte enables for the write |
| cfg_wdata | input | 16 | Write data |
| cfg_rdata | output | 16 | Combinational read data for `cfg_addr` |
| pme_event | input | 1 | Event request from device logic |
| aux_present | input | 1 | Auxiliary power present; sets the enable reset value |
| pme_out | output | 1 | Registered PME request |
| pwr_state | output | 2 | Current power state code |

## Verification
The bench builds the block with `SUPPORTED_MASK = 4'b1011`, so D1 is supported and D2 is not. With this value, one run covers both the accepted path and the discarded path for an optional state, and the capabilities word shows one support bit set and one clear. The bench resets the block once with auxiliary power present and once without it, which covers both reset values of the enable bit. It also applies an event in the same cycle as a clearing write, to cover the ordering in R6.

// File: rtl/pm_cap_pkg.sv
package pm_cap_pkg;
   typedef enum logic [1:0] {
      PS_D0 = 2'd0,
      PS_D1 = 2'd1,
      PS_D2 = 2'd2,
      PS_D3 = 2'd3
   } pstate_e;

   localparam int unsigned WORD_W     = 16;
   localparam int unsigned N_PSTATES  = 4;
   localparam int unsigned SEL_W      = 4;
   localparam int unsigned SEL_LSB    = 9;
   localparam int unsigned EN_BIT     = 8;
   localparam int unsigned STAT_BIT   = 15;
   localparam logic [1:0]  SCALE_VAL  = 2'b01;
   localparam logic [2:0]  SPEC_VER   = 3'b010;
   localparam int unsigned CAP_D1_BIT = 9;
   localparam int unsigned CAP_D2_BIT = 10;
endpackage

// File: rtl/pm_cap_word.sv
module pm_cap_word
   import pm_cap_pkg::*;
#(
   parameter int unsigned N_ST = N_PSTATES
) (
   input  logic [N_ST-1:0]   supported,
   output logic [WORD_W-1:0] cap_word
);
   always_comb begin
      cap_word             = '0;
      cap_word[2:0]        = SPEC_VER;
      cap_word[CAP_D1_BIT] = supported[1];
      cap_word[CAP_D2_BIT] = supported[2];
   end
endmodule

// File: rtl/pm_state_reg.sv
module pm_state_reg
   import pm_cap_pkg::*;
#(
   parameter int unsigned N_ST = N_PSTATES
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            wr_en,
   input  pstate_e         wr_state,
   input  logic [N_ST-1:0] supported,
   output pstate_e         state_q
);
   always_ff @(posedge clk) begin
      if (!rst_n)
         state_q <= PS_D0;
      else if (wr_en && supported[wr_state])
         state_q <= wr_state;
   end

   // R4
   unsupported_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && !supported[wr_state]) |=> $stable(state_q));

   // R3
   state_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
      supported[state_q]);
endmodule

// File: rtl/pm_event_reg.sv
module pm_event_reg
   import pm_cap_pkg::*;
#(
   parameter int unsigned DSEL_W = SEL_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              aux_present,
   input  logic              pme_event,
   input  logic              hi_wr,
   input  logic              wr_en_bit,
   input  logic [DSEL_W-1:0] wr_dsel,
   input  logic              wr_clr,
   output logic              status_q,
   output logic              en_q,
   output logic [DSEL_W-1:0] dsel_q,
   output logic              pme_out
);
   logic status_d;
   logic en_d;
   logic clr_now;

   assign clr_now = hi_wr & wr_clr;

   always_comb begin
      status_d = pme_event | (status_q & ~clr_now);
      en_d     = hi_wr ? wr_en_bit : en_q;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         status_q <= 1'b0;
         en_q     <= aux_present;
         dsel_q   <= '0;
         pme_out  <= 1'b0;
      end else begin
         status_q <= status_d;
         en_q     <= en_d;
         if (hi_wr)
            dsel_q <= wr_dsel;
         pme_out  <= status_d & en_d;
      end
   end

   // R5
   event_sets_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pme_event |=> status_q);

   // R6
   status_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (status_q && !clr_now) |=> status_q);

   // R7
   clear_drops_pme_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_now && !pme_event) |=> !pme_out);

   // R7
   pme_needs_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pme_out |-> (status_q && en_q));

   // R2
   en_reset_value_chk: assert property (@(posedge clk)
      !rst_n |=> (en_q == $past(aux_present)));
endmodule

// File: rtl/pm_cap_regs.sv
module pm_cap_regs
   import pm_cap_pkg::*;
#(
   parameter int unsigned ADDR_W         = 2,
   parameter logic [3:0]  SUPPORTED_MASK = 4'b1111,
   parameter int unsigned CAP_IDX        = 0,
   parameter int unsigned CSR_IDX        = 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_wr,
   input  logic [ADDR_W-1:0] cfg_addr,
   input  logic [1:0]        cfg_be,
   input  logic [15:0]       cfg_wdata,
   output logic [15:0]       cfg_rdata,
   input  logic              pme_event,
   input  logic              aux_present,
   output logic              pme_out,
   output logic [1:0]        pwr_state
);
   localparam int unsigned N_WORDS = 1 << ADDR_W;
   localparam int unsigned BE_W    = WORD_W / 8;

   if (ADDR_W < 2) begin : g_addr_chk
      $error("ADDR_W must cover the capability, control and extension words");
   end
   if (CAP_IDX == CSR_IDX) begin : g_idx_chk
      $error("CAP_IDX and CSR_IDX must differ");
   end
   if (CAP_IDX >= N_WORDS || CSR_IDX >= N_WORDS) begin : g_range_chk
      $error("word index outside the address range");
   end
   if (BE_W != 2) begin : g_be_chk
      $error("control word must be two bytes wide");
   end

   logic [N_PSTATES-1:0] supported;
   for (genvar i = 0; i < N_PSTATES; i++) begin : g_sup
      if (i == 0 || i == N_PSTATES - 1) begin : g_mand
         assign supported[i] = 1'b1;
      end else begin : g_opt
         assign supported[i] = SUPPORTED_MASK[i];
      end
   end

   logic csr_hit;
   logic lo_wr;
   logic hi_wr;
   assign csr_hit = cfg_wr && (cfg_addr == ADDR_W'(CSR_IDX));
   assign lo_wr   = csr_hit & cfg_be[0];
   assign hi_wr   = csr_hit & cfg_be[1];

   logic [WORD_W-1:0] cap_word;
   pm_cap_word #(.N_ST(N_PSTATES)) u_cap (
      .supported (supported),
      .cap_word  (cap_word)
   );

   pstate_e state_q;
   pm_state_reg #(.N_ST(N_PSTATES)) u_state (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_en     (lo_wr),
      .wr_state  (pstate_e'(cfg_wdata[1:0])),
      .supported (supported),
      .state_q   (state_q)
   );

   logic             status_q;
   logic             en_q;
   logic [SEL_W-1:0] dsel_q;
   pm_event_reg #(.DSEL_W(SEL_W)) u_event (
      .clk         (clk),
      .rst_n       (rst_n),
      .aux_present (aux_present),
      .pme_event   (pme_event),
      .hi_wr       (hi_wr),
      .wr_en_bit   (cfg_wdata[EN_BIT]),
      .wr_dsel     (cfg_wdata[SEL_LSB +: SEL_W]),
      .wr_clr      (cfg_wdata[STAT_BIT]),
      .status_q    (status_q),
      .en_q        (en_q),
      .dsel_q      (dsel_q),
      .pme_out     (pme_out)
   );

   logic [WORD_W-1:0] csr_word;
   always_comb begin
      csr_word                      = '0;
      csr_word[1:0]                 = state_q;
      csr_word[EN_BIT]              = en_q;
      csr_word[SEL_LSB +: SEL_W]    = dsel_q;
      csr_word[STAT_BIT-1 -: 2]     = SCALE_VAL;
      csr_word[STAT_BIT]            = status_q;
   end

   always_comb begin
      if (cfg_addr == ADDR_W'(CAP_IDX))
         cfg_rdata = cap_word;
      else if (cfg_addr == ADDR_W'(CSR_IDX))
         cfg_rdata = csr_word;
      else
         cfg_rdata = '0;
   end

   assign pwr_state = state_q;

   // R8
   lo_lane_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (csr_hit && !cfg_be[0]) |=> $stable(pwr_state));

   // R8
   hi_lane_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (csr_hit && !cfg_be[1] && !pme_event) |=> $stable(cfg_rdata[12:8]));
endmodule

// File: tb/sim_pm_cap_regs.sv
module sim_pm_cap_regs;
   localparam logic [3:0] MASK = 4'b1011;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_wr = 1'b0;
   logic [1:0]  cfg_addr = 2'd0;
   logic [1:0]  cfg_be = 2'b00;
   logic [15:0] cfg_wdata = 16'h0;
   logic [15:0] cfg_rdata;
   logic        pme_event = 1'b0;
   logic        aux_present = 1'b1;
   logic        pme_out;
   logic [1:0]  pwr_state;

   int n_chk = 0;
   int n_fail = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;

   pm_cap_regs #(.ADDR_W(2), .SUPPORTED_MASK(MASK)) u0 (
      .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_addr(cfg_addr),
      .cfg_be(cfg_be), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
      .pme_event(pme_event), .aux_present(aux_present),
      .pme_out(pme_out), .pwr_state(pwr_state)
   );

   task automatic chk(input string tag, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
      end
   endtask

   // reference model
   int m_state = 0, m_dsel = 0, m_en = 0, m_stat = 0, m_pme = 0;
   bit started = 1'b0;

   function automatic bit sup(input int s);
      logic [3:0] v;
      v = MASK | 4'b1001;
      return v[s];
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         m_state = 0; m_dsel = 0; m_stat = 0; m_pme = 0;
         m_en = int'(aux_present);
      end else begin
         bit w1;
         bit clr;
         w1 = cfg_wr && (cfg_addr == 2'd1);
         clr = w1 && cfg_be[1] && cfg_wdata[15];
         if (w1 && cfg_be[0] && sup(int'(cfg_wdata[1:0])))
            m_state = int'(cfg_wdata[1:0]);
         if (w1 && cfg_be[1]) begin
            m_dsel = int'(cfg_wdata[12:9]);
            m_en   = int'(cfg_wdata[8]);
         end
         m_stat = (pme_event || (m_stat != 0 && !clr)) ? 1 : 0;
         m_pme  = m_stat & m_en;
      end
      started = 1'b1;
      #5;
      chk("R3 pwr_state", int'(pwr_state), m_state);
      chk("R7 pme_out", int'(pme_out), m_pme);
      case (cfg_addr)
         2'd0: chk("R10 cap word", int'(cfg_rdata), 16'h0202);
         2'd1: begin
            chk("R5 status bit", int'(cfg_rdata[15]), m_stat);
            chk("R2 enable bit", int'(cfg_rdata[8]), m_en);
            chk("R9 data select", int'(cfg_rdata[12:9]), m_dsel);
            chk("R9 scale and zero bits",
                int'({cfg_rdata[14:13], cfg_rdata[7:2]}), 8'b01_000000);
            chk("R3 state field", int'(cfg_rdata[1:0]), m_state);
         end
         default: chk("R11 empty word", int'(cfg_rdata), 0);
      endcase
   end

   task automatic wr(input logic [1:0] a, input logic [1:0] be,
                     input logic [15:0] d, input bit ev);
      @(negedge clk);
      cfg_wr = 1'b1; cfg_addr = a; cfg_be = be; cfg_wdata = d; pme_event = ev;
      @(negedge clk);
      cfg_wr = 1'b0; cfg_be = 2'b00; cfg_wdata = 16'h0; pme_event = 1'b0;
   endtask

   task automatic rd_chk(input string tag, input logic [1:0] a, input int exp);
      cfg_addr = a;
      #1;
      chk(tag, int'(cfg_rdata), exp);
   endtask

   task automatic do_reset(input bit aux);
      @(negedge clk);
      aux_present = aux; rst_n = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
   endtask

   initial begin
      do_reset(1'b1);
      rd_chk("R1 R2 control after reset", 2'd1, 16'h2100);
      chk("R1 pme_out after reset", int'(pme_out), 0);
      rd_chk("R10 capability word", 2'd0, 16'h0202);
      rd_chk("R11 index 2", 2'd2, 0);
      rd_chk("R11 index 3", 2'd3, 0);
      wr(2'd0, 2'b11, 16'hFFFF, 1'b0);
      rd_chk("R10 write ignored", 2'd0, 16'h0202);
      wr(2'd2, 2'b11, 16'hFFFF, 1'b0);
      rd_chk("R11 write ignored", 2'd2, 0);
      rd_chk("R11 control untouched", 2'd1, 16'h2100);

      wr(2'd1, 2'b01, 16'h0001, 1'b0);
      chk("R3 enter D1", int'(pwr_state), 1);
      wr(2'd1, 2'b01, 16'h0002, 1'b0);
      chk("R4 D2 discarded", int'(pwr_state), 1);
      wr(2'd1, 2'b01, 16'h0003, 1'b0);
      chk("R3 enter D3", int'(pwr_state), 3);
      wr(2'd1, 2'b01, 16'h0000, 1'b0);
      chk("R3 enter D0", int'(pwr_state), 0);

      wr(2'd1, 2'b01, 16'h1E03, 1'b0);
      rd_chk("R8 low lane only", 2'd1, 16'h2103);
      wr(2'd1, 2'b10, 16'h1801, 1'b0);
      rd_chk("R8 high lane only", 2'd1, 16'h3803);
      wr(2'd1, 2'b11, 16'h0100, 1'b0);
      rd_chk("R9 both lanes", 2'd1, 16'h2100);

      @(negedge clk); pme_event = 1'b1;
      @(negedge clk); pme_event = 1'b0;
      rd_chk("R5 status set", 2'd1, 16'hA100);
      chk("R7 pme raised", int'(pme_out), 1);
      wr(2'd1, 2'b10, 16'h0100, 1'b0);
      rd_chk("R6 zero write keeps status", 2'd1, 16'hA100);
      wr(2'd1, 2'b10, 16'h8100, 1'b0);
      rd_chk("R6 one write clears", 2'd1, 16'h2100);
      chk("R7 pme dropped after clear", int'(pme_out), 0);

      wr(2'd1, 2'b10, 16'h0000, 1'b0);
      @(negedge clk); pme_event = 1'b1;
      @(negedge clk); pme_event = 1'b0;
      rd_chk("R5 status while disabled", 2'd1, 16'hA000);
      chk("R7 pme held low while disabled", int'(pme_out), 0);
      wr(2'd1, 2'b10, 16'h0100, 1'b0);
      chk("R7 pme after enable", int'(pme_out), 1);

      wr(2'd1, 2'b10, 16'h8100, 1'b1);
      rd_chk("R6 event beats clear", 2'd1, 16'hA100);
      wr(2'd1, 2'b10, 16'h8100, 1'b0);
      rd_chk("R6 final clear", 2'd1, 16'h2100);

      wr(2'd1, 2'b11, 16'h1A01, 1'b0);
      do_reset(1'b0);
      rd_chk("R1 R2 reset without aux", 2'd1, 16'h2000);
      chk("R1 state after second reset", int'(pwr_state), 0);
      repeat (3) @(negedge clk);

      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      repeat (5000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end
endmodule